// File: doc/BRIEF.md
# Timer Compare Waveform Output Unit

An 8-bit timer/counter with one compare channel. It generates a single waveform output and decides, through its output logic, whether that waveform or the ordinary port value appears on the pin. Software writes a control register and a compare register. The control register has two fields: a 2-bit output-action field and a 3-bit waveform-kind field. The counter advances only on cycles where the tick enable is high. It runs in one of four waveform kinds: free-running, clear-on-compare, single-slope PWM and dual-slope PWM.

The effect of the output-action field depends on the waveform kind and on the count direction. In the PWM kinds, compare values are double-buffered, so a period is never cut short by a write. The output driver enable follows the data-direction input in every case.

Top module: `cwt_top`

## Requirements
- R1: After reset, the counter, the output register, both control fields, both compare registers and the direction flag are 0. In this state the pin shows `port_val_i`.
- R2: The timer is connected to the pin when the action field is nonzero, except for action 01 in a PWM kind while wave-kind bit 2 is 0. When connected, `pin_o` is the output register; otherwise it is `port_val_i`. `pin_oe_o` always equals `dir_i`.
- R3: Wave-kind codes 000, 100 and 110 select free-running mode. On each tick the counter adds 1 and wraps from 0xFF to 0.
- R4: Wave-kind 010 selects clear-on-compare mode. A tick while the counter equals the active compare value loads 0; any other tick adds 1.
- R5: Codes 011 and 111 select single-slope PWM. The limit is 0xFF for 011 and the active compare value for 111. A tick at the limit loads 0; any other tick adds 1.
- R6: Codes 001 and 101 select dual-slope PWM, with the limit chosen as in R5 (0xFF when bit 2 is 0, the compare value when it is 1). Counting up, a tick at or above the limit reverses the direction and steps down. Counting down, a tick at 0 reverses the direction and steps up.
- R7: In free-running and clear-on-compare modes, a tick with the counter equal to the compare value acts by action code. 00 holds the output, 01 inverts it, 10 clears it and 11 sets it.
- R8: In single-slope PWM, action 10 clears the output on a compare tick and sets it on a tick at the limit. Action 11 sets the output on a compare tick and clears it at the limit.
- R9: In either PWM kind, action 01 holds the output when wave-kind bit 2 is 0. When that bit is 1, action 01 inverts the output on a compare tick.
- R10: In dual-slope PWM, a compare tick counting up clears the output for action 10 and sets it for action 11. A compare tick counting down does the opposite.
- R11: In single-slope PWM with action 1x, a tick where the compare value equals the limit applies only the limit action.
- R12: A compare write reaches the active compare value at once in free-running and clear-on-compare modes. In single-slope PWM it takes effect on a tick at the limit; in dual-slope PWM, on a tick at 0.
- R13: Without a tick, the counter, the direction and the output register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick enable |
| ctrl_we_i | input | 1 | Control register write strobe |
| out_mode_i | input | 2 | Output-action field write data |
| wave_mode_i | input | 3 | Waveform-kind field write data |
| cmp_we_i | input | 1 | Compare register write strobe |
| cmp_data_i | input | 8 | Compare register write data |
| dir_i | input | 1 | Data-direction bit for the pin |
| port_val_i | input | 1 | Ordinary port value for the pin |
| cnt_o | output | 8 | Counter value |
| pin_o | output | 1 | Pin value |
| pin_oe_o | output | 1 | Pin driver enable |

## Verification
The counter, the direction and the output register change on the clock edge at which a tick is presented, so their new values are due one edge after the inputs are driven. Control and compare writes likewise take effect on that same edge. `pin_o` and `pin_oe_o` follow `port_val_i` and `dir_i` combinationally, in the same cycle. The bench drives inputs on the falling edge and advances its model over the following rising edge. It compares all outputs at the next falling edge, before the next stimulus is driven, so every comparison falls exactly one edge after its cause.

// File: rtl/cwt_pkg.sv
package cwt_pkg;
  typedef enum logic [1:0] {WM_FREE, WM_CLR, WM_FAST, WM_DUAL} wave_kind_e;

  function automatic wave_kind_e decode_kind(input logic [2:0] code);
    unique case (code)
      3'b010:         decode_kind = WM_CLR;
      3'b011, 3'b111: decode_kind = WM_FAST;
      3'b001, 3'b101: decode_kind = WM_DUAL;
      default:        decode_kind = WM_FREE;
    endcase
  endfunction
endpackage

// File: rtl/cwt_cmp_buf.sv
module cwt_cmp_buf
  import cwt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  wave_kind_e       kind_i,
  input  logic             var_top_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] cnt_i,
  output logic [WIDTH-1:0] ocr_o,
  output logic [WIDTH-1:0] top_o
);
  localparam logic [WIDTH-1:0] MaxVal = '1;

  logic [WIDTH-1:0] buf_q, buf_d, act_q, act_d;

  assign buf_d = we_i ? data_i : buf_q;
  assign top_o = (kind_i == WM_CLR || var_top_i) ? act_q : MaxVal;
  assign ocr_o = act_q;

  always_comb begin
    act_d = act_q;
    unique case (kind_i)
      WM_FAST: if (tick_i && cnt_i == top_o) act_d = buf_q;
      WM_DUAL: if (tick_i && cnt_i == '0) act_d = buf_q;
      default: act_d = buf_d;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      buf_q <= buf_d;
      act_q <= act_d;
    end
  end

  AST_FAST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == WM_FAST && !(tick_i && cnt_i == top_o)) |=> $stable(act_q)); // R12
endmodule

// File: rtl/cwt_counter.sv
module cwt_counter
  import cwt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  wave_kind_e       kind_i,
  input  logic [WIDTH-1:0] top_i,
  input  logic [WIDTH-1:0] ocr_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             dn_o
);
  localparam logic [WIDTH-1:0] One = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             dn_q, dn_d;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    if (tick_i) begin
      unique case (kind_i)
        WM_CLR: begin
          cnt_d = (cnt_q == ocr_i) ? '0 : cnt_q + One;
          dn_d  = 1'b0;
        end
        WM_FAST: begin
          cnt_d = (cnt_q == top_i) ? '0 : cnt_q + One;
          dn_d  = 1'b0;
        end
        WM_DUAL: begin
          if (!dn_q) begin
            if (cnt_q >= top_i) begin
              dn_d  = 1'b1;
              cnt_d = (cnt_q == '0) ? '0 : cnt_q - One;
            end else begin
              cnt_d = cnt_q + One;
            end
          end else if (cnt_q == '0) begin
            dn_d  = 1'b0;
            cnt_d = (top_i == '0) ? '0 : One;
          end else begin
            cnt_d = cnt_q - One;
          end
        end
        default: begin
          cnt_d = cnt_q + One;
          dn_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign cnt_o = cnt_q;
  assign dn_o  = dn_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(cnt_q) && $stable(dn_q))); // R13
  AST_FREE_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && kind_i == WM_FREE) |=> cnt_q == WIDTH'($past(cnt_q) + One)); // R3
  AST_CLR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && kind_i == WM_CLR && cnt_q == ocr_i) |=> cnt_q == '0); // R4
  AST_FAST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && kind_i == WM_FAST && cnt_q == top_i) |=> cnt_q == '0); // R5
  AST_DUAL_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && kind_i == WM_DUAL && !dn_q && cnt_q >= top_i && cnt_q != '0) |=> dn_q); // R6
endmodule

// File: rtl/cwt_wave_out.sv
module cwt_wave_out
  import cwt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  wave_kind_e       kind_i,
  input  logic             var_top_i,
  input  logic [1:0]       om_i,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic [WIDTH-1:0] top_i,
  input  logic [WIDTH-1:0] ocr_i,
  input  logic             dn_i,
  input  logic             dir_i,
  input  logic             port_val_i,
  output logic             pin_o,
  output logic             pin_oe_o
);
  logic wave_q, wave_d, match, at_top, pwm, conn;

  assign match  = (cnt_i == ocr_i);
  assign at_top = (cnt_i == top_i);
  assign pwm    = (kind_i == WM_FAST) || (kind_i == WM_DUAL);
  // action 01 in a PWM kind needs the variable-limit bit to reach the pin
  assign conn   = (om_i != 2'b00) && !(pwm && om_i == 2'b01 && !var_top_i);

  always_comb begin
    wave_d = wave_q;
    if (tick_i) begin
      unique case (kind_i)
        WM_FAST, WM_DUAL: begin
          if (om_i == 2'b01) begin
            if (var_top_i && match) wave_d = !wave_q;
          end else if (om_i[1]) begin
            if (kind_i == WM_FAST) begin
              if (at_top)     wave_d = !om_i[0];  // limit action beats the match
              else if (match) wave_d = om_i[0];
            end else if (match) begin
              wave_d = om_i[0] ^ dn_i;
            end
          end
        end
        default: begin
          if (match) begin
            unique case (om_i)
              2'b01:   wave_d = !wave_q;
              2'b10:   wave_d = 1'b0;
              2'b11:   wave_d = 1'b1;
              default: wave_d = wave_q;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= wave_d;
  end

  assign pin_o    = conn ? wave_q : port_val_i;
  assign pin_oe_o = dir_i;

  AST_WAVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(wave_q)); // R13
  AST_FAST_LIMIT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && kind_i == WM_FAST && om_i[1] && at_top) |=> wave_q == !$past(om_i[0])); // R11
  AST_PLAIN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !pwm && om_i == 2'b11 && match) |=> wave_q); // R7
endmodule

// File: rtl/cwt_top.sv
module cwt_top
  import cwt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ctrl_we_i,
  input  logic [1:0]       out_mode_i,
  input  logic [2:0]       wave_mode_i,
  input  logic             cmp_we_i,
  input  logic [WIDTH-1:0] cmp_data_i,
  input  logic             dir_i,
  input  logic             port_val_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             pin_o,
  output logic             pin_oe_o
);
  logic [1:0]       om_q;
  logic [2:0]       wm_q;
  wave_kind_e       kind;
  logic [WIDTH-1:0] ocr, top, cnt;
  logic             dn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      om_q <= '0;
      wm_q <= '0;
    end else if (ctrl_we_i) begin
      om_q <= out_mode_i;
      wm_q <= wave_mode_i;
    end
  end

  assign kind  = decode_kind(wm_q);
  assign cnt_o = cnt;

  cwt_cmp_buf #(.WIDTH(WIDTH)) u_buf (
    .clk_i, .rst_ni, .tick_i, .kind_i(kind), .var_top_i(wm_q[2]),
    .we_i(cmp_we_i), .data_i(cmp_data_i), .cnt_i(cnt), .ocr_o(ocr), .top_o(top)
  );

  cwt_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .kind_i(kind), .top_i(top), .ocr_i(ocr),
    .cnt_o(cnt), .dn_o(dn)
  );

  cwt_wave_out #(.WIDTH(WIDTH)) u_wave (
    .clk_i, .rst_ni, .tick_i, .kind_i(kind), .var_top_i(wm_q[2]), .om_i(om_q),
    .cnt_i(cnt), .top_i(top), .ocr_i(ocr), .dn_i(dn), .dir_i, .port_val_i,
    .pin_o, .pin_oe_o
  );
endmodule

// File: tb/tb_cwt_top.sv
`timescale 1ns/1ps
module tb_cwt_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 0, ctrl_we_i = 0, cmp_we_i = 0, dir_i = 0, port_val_i = 0;
  logic [1:0] out_mode_i = '0;
  logic [2:0] wave_mode_i = '0;
  logic [7:0] cmp_data_i = '0;
  logic [7:0] cnt_o;
  logic       pin_o, pin_oe_o;

  always #2.5 clk = ~clk;

  cwt_top dut (
    .clk_i(clk), .rst_ni, .tick_i, .ctrl_we_i, .out_mode_i, .wave_mode_i,
    .cmp_we_i, .cmp_data_i, .dir_i, .port_val_i, .cnt_o, .pin_o, .pin_oe_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string force_tag = "";

  // bench model
  logic [1:0] m_om = '0;
  logic [2:0] m_wm = '0;
  logic [7:0] m_cnt = '0, m_buf = '0, m_act = '0;
  logic       m_dn = 0, m_wave = 0;

  // 0 free, 1 clear-on-compare, 2 single-slope, 3 dual-slope
  function automatic int kind_of(logic [2:0] w);
    case (w)
      3'b010: return 1;
      3'b011, 3'b111: return 2;
      3'b001, 3'b101: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic bit conn_of(logic [1:0] om, logic [2:0] wm);
    if (om == 2'b00) return 0;
    if (kind_of(wm) >= 2 && om == 2'b01 && !wm[2]) return 0;
    return 1;
  endfunction

  function automatic logic [7:0] top_of();
    return (kind_of(m_wm) == 1 || m_wm[2]) ? m_act : 8'hFF;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    string tc, tp;
    int k = kind_of(m_wm);
    bit c = conn_of(m_om, m_wm);
    tc = (k == 0) ? "R3" : (k == 1) ? "R4" : (k == 2) ? "R5" : "R6";
    if (!c) tp = "R2";
    else if (k < 2) tp = "R7";
    else if (m_om == 2'b01) tp = "R9";
    else if (k == 2) tp = "R8";
    else tp = "R10";
    if (force_tag != "") begin tc = force_tag; tp = force_tag; end
    chk(tc, "cnt_o", int'(cnt_o), int'(m_cnt));
    chk(tp, "pin_o", int'(pin_o), int'(c ? m_wave : port_val_i));
    chk((force_tag != "") ? force_tag : "R2", "pin_oe_o", int'(pin_oe_o), int'(dir_i));
  endtask

  task automatic model_update();
    int k = kind_of(m_wm);
    logic [7:0] top = top_of();
    logic [7:0] nc = m_cnt, nb, na = m_act;
    logic nd = m_dn, nw = m_wave;
    bit match = (m_cnt == m_act);
    nb = cmp_we_i ? cmp_data_i : m_buf;
    if (tick_i) begin
      case (k)
        1: begin nc = match ? 8'd0 : m_cnt + 8'd1; nd = 0; end
        2: begin nc = (m_cnt == top) ? 8'd0 : m_cnt + 8'd1; nd = 0; end
        3: begin
          if (!m_dn) begin
            if (m_cnt >= top) begin nd = 1; nc = (m_cnt == 0) ? 8'd0 : m_cnt - 8'd1; end
            else nc = m_cnt + 8'd1;
          end else if (m_cnt == 0) begin nd = 0; nc = (top == 0) ? 8'd0 : 8'd1; end
          else nc = m_cnt - 8'd1;
        end
        default: begin nc = m_cnt + 8'd1; nd = 0; end
      endcase
      if (k < 2) begin
        if (match)
          case (m_om)
            2'b01: nw = !m_wave;
            2'b10: nw = 0;
            2'b11: nw = 1;
            default: ;
          endcase
      end else if (m_om == 2'b01) begin
        if (m_wm[2] && match) nw = !m_wave;
      end else if (m_om[1]) begin
        if (k == 2) begin
          if (m_cnt == top) nw = !m_om[0];
          else if (match) nw = m_om[0];
        end else if (match) nw = m_om[0] ^ m_dn;
      end
    end
    if (k < 2) na = nb;
    else if (k == 2 && tick_i && m_cnt == top) na = m_buf;
    else if (k == 3 && tick_i && m_cnt == 0) na = m_buf;
    m_cnt = nc; m_dn = nd; m_wave = nw; m_buf = nb; m_act = na;
    if (ctrl_we_i) begin m_om = out_mode_i; m_wm = wave_mode_i; end
  endtask

  task automatic step(bit tk, bit cwe, logic [1:0] om, logic [2:0] wm,
                      bit owe, logic [7:0] od, bit dir, bit pv);
    @(negedge clk);
    check_all();
    tick_i = tk; ctrl_we_i = cwe; out_mode_i = om; wave_mode_i = wm;
    cmp_we_i = owe; cmp_data_i = od; dir_i = dir; port_val_i = pv;
    model_update();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state, pin follows port
    force_tag = "R1";
    step(0, 0, 2'b00, 3'b000, 0, 8'd0, 0, 1);
    step(0, 0, 2'b00, 3'b000, 0, 8'd0, 1, 0);
    step(1, 0, 2'b00, 3'b000, 0, 8'd0, 1, 1);
    // R11: single-slope, compare equals variable limit, clear-on-compare action
    force_tag = "R11";
    step(1, 1, 2'b10, 3'b111, 1, 8'd30, 1, 0);
    for (int i = 0; i < 200; i++) step(1, 0, 2'b10, 3'b111, 0, 8'd0, 1, 0);
    step(1, 1, 2'b11, 3'b111, 0, 8'd0, 1, 1);
    for (int i = 0; i < 100; i++) step(1, 0, 2'b11, 3'b111, 0, 8'd0, 1, 1);
    // R12: buffered compare write in single-slope and dual-slope PWM
    force_tag = "R12";
    step(1, 1, 2'b11, 3'b111, 1, 8'd40, 1, 0);
    for (int i = 0; i < 90; i++) step(1, 0, 2'b11, 3'b111, 0, 8'd0, 1, 0);
    step(1, 0, 2'b11, 3'b111, 1, 8'd10, 1, 0);
    for (int i = 0; i < 60; i++) step(1, 0, 2'b11, 3'b111, 0, 8'd0, 1, 0);
    step(1, 1, 2'b10, 3'b101, 1, 8'd25, 1, 0);
    for (int i = 0; i < 80; i++) step(1, 0, 2'b10, 3'b101, (i == 30), 8'd12, 1, 0);
    // R13: no tick, counter and output frozen while compare writes land
    force_tag = "R13";
    step(1, 1, 2'b01, 3'b000, 0, 8'd0, 1, 0);
    for (int i = 0; i < 50; i++) step(0, 0, 2'b01, 3'b000, 1, 8'(i), 1, 0);
    // R9: toggle action disconnected in fixed-limit PWM
    force_tag = "R9";
    step(1, 1, 2'b01, 3'b011, 0, 8'd0, 1, 1);
    for (int i = 0; i < 40; i++) step(1, 0, 2'b01, 3'b011, 0, 8'd0, 1, (i % 3) == 0);
    step(1, 1, 2'b01, 3'b111, 1, 8'd7, 1, 0);
    for (int i = 0; i < 60; i++) step(1, 0, 2'b01, 3'b111, 0, 8'd0, 1, 0);
    // random stimulus, tags chosen per mode
    force_tag = "";
    for (int i = 0; i < 20000; i++) begin
      bit cwe = ($urandom % 96) == 0;
      bit owe = ($urandom % 16) == 0;
      step(($urandom % 4) != 0, cwe, 2'($urandom), 3'($urandom),
           owe, 8'($urandom % 64), ($urandom % 8) != 0, 1'($urandom));
    end
    @(negedge clk);
    check_all();
    done = 1;
    summary();
    $finish;
  end
endmodule